// File: doc/BRIEF.md
# Multi-Master I2C Byte Sender with Arbitration Fallback

This block sends one byte as a master on a shared two-wire bus where other masters may be active at the same time. A start request launches a START condition, eight data bits sent MSB first and a ninth (acknowledge) clock. The block drives open-drain SCL and SDA through pull-low enables and reads the resolved line levels back. It also watches the bus for START and STOP conditions from any master and keeps a bus-busy indication.

When the block lets SDA float to send a 1 but reads the line low while SCL is high, it has lost arbitration. From then on it stops driving SDA and behaves as a receiver, but it still clocks SCL to the end of the ninth pulse so the byte on the wire completes. On the falling edge of that ninth pulse it raises the lost flag and the interrupt and drops the master bit. It never issues a STOP after a loss. A start request made while another master owns the bus is refused: nothing appears on the lines, the master bit stays 0, and the lost flag and interrupt are raised at once. The flag and interrupt stay set until software writes the clear strobe. A byte that wins ends with a STOP and a one-cycle done pulse.

Top module: `i2c_arb_master`

## Requirements
- R1: After reset both pull-low enables are 0, and the master bit, lost flag, interrupt and bus-busy outputs are all 0.
- R2: A start request on an idle, free bus makes a START (SDA pulled low while SCL is released) and then nine SCL pulses. SDA is pulled low during a data pulse exactly when that bit of the transmit byte is 0, MSB first, and is released during the ninth pulse. SDA does not change while the block leaves SCL high. The master bit reads 1 from acceptance until the ninth falling edge.
- R3: If SDA reads low while SCL is high during a data bit that the block sends as 1, the block releases SDA for every later bit of that byte.
- R4: After a loss the block keeps driving SCL and itself produces the falling edge that ends the ninth pulse.
- R5: At that ninth falling edge of a lost byte, the lost flag and interrupt read 1 and the master bit reads 0. The lost flag reads 0 before it.
- R6: A byte that keeps arbitration ends with a STOP, one cycle of xfer_done, the master bit back at 0 and the lost flag at 0.
- R7: bus_busy becomes 1 after SDA falls while SCL is high, and returns to 0 after SDA rises while SCL is high.
- R8: A start request while bus_busy is 1 leaves both enables at 0, leaves the master bit at 0, and sets the lost flag and interrupt on the next cycle.
- R9: The al_clr strobe clears the lost flag and the interrupt. If a new loss or refusal sets them in the same cycle, the set wins.
- R10: After a loss the block issues no STOP. SDA stays released through the ninth falling edge, and both lines are released afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle request to take the bus and send tx_byte |
| tx_byte | input | DATA_W | Byte to send, MSB first |
| al_clr | input | 1 | Write-one-to-clear strobe for the lost flag and interrupt |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| mm_bit | output | 1 | Master-mode status |
| al_flag | output | 1 | Arbitration-lost flag |
| irq | output | 1 | Interrupt request, held until cleared |
| bus_busy | output | 1 | Bus owned by some master |
| xfer_done | output | 1 | One-cycle pulse after a won byte's STOP |

## Verification
The clear strobe and a new set event can land on the same clock. The bench provokes this by repeating a refused start request in the very cycle it writes al_clr, while the flag is already set. It judges the outcome from the flag, which must stay 1, and then confirms that a lone clear does drop it. The sweep also pits every transmit byte against a fixed competitor byte and against an identical one. This makes a loss on the last data bit coincide with the edge that starts the ninth pulse, and the flag's timing is checked on that falling edge.

// File: rtl/i2c_arb_pkg.sv
package i2c_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_A,
        ST_START_B,
        ST_BIT,
        ST_END,
        ST_STOP_B,
        ST_STOP_C
    } mst_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drv_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic busy;
    } bus_view_t;

    // Pull-low pattern for a state and quarter of the SCL period.
    function automatic line_drv_t line_drive(
        input mst_state_e st,
        input logic [1:0] q,
        input logic       data_phase,
        input logic       bit_val,
        input logic       lost
    );
        line_drv_t d;
        d.scl_low = 1'b0;
        d.sda_low = 1'b0;
        case (st)
            ST_START_A: d.sda_low = 1'b1;
            ST_START_B: begin d.scl_low = 1'b1; d.sda_low = 1'b1; end
            ST_BIT: begin
                d.scl_low = ~q[1];
                d.sda_low = data_phase & ~bit_val & ~lost;
            end
            ST_END: begin d.scl_low = 1'b1; d.sda_low = ~lost; end
            ST_STOP_B: d.sda_low = 1'b1;
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
    parameter int QDIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = en && (cnt == CW'(QDIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !en || tick) cnt <= '0;
        else                    cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/i2c_line_watch.sv
module i2c_line_watch
    import i2c_arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_in,
    input  logic      sda_in,
    output bus_view_t view
);
    logic scl_s, sda_s, scl_p, sda_p, busy_q;
    logic start_seen, stop_seen;

    assign start_seen = scl_s & scl_p &  sda_p & ~sda_s;
    assign stop_seen  = scl_s & scl_p & ~sda_p &  sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_s  <= 1'b1;
            sda_s  <= 1'b1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            scl_s <= scl_in;
            sda_s <= sda_in;
            scl_p <= scl_s;
            sda_p <= sda_s;
            if (start_seen)     busy_q <= 1'b1;
            else if (stop_seen) busy_q <= 1'b0;
        end
    end

    assign view.scl  = scl_s;
    assign view.sda  = sda_s;
    assign view.busy = busy_q;

    p_busy_start_r7: assert property (@(posedge clk) disable iff (rst)
        start_seen |=> busy_q);
    p_busy_stop_r7: assert property (@(posedge clk) disable iff (rst)
        stop_seen |=> !busy_q);
endmodule

// File: rtl/i2c_arb_flags.sv
module i2c_arb_flags (
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic refuse,
    input  logic lost_evt,
    input  logic done_evt,
    input  logic al_clr,
    output logic mm_bit,
    output logic al_flag,
    output logic irq
);
    logic set_evt;
    assign set_evt = refuse | lost_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mm_bit  <= 1'b0;
            al_flag <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (set_evt || done_evt) mm_bit <= 1'b0;
            else if (accept)         mm_bit <= 1'b1;
            if (set_evt)     al_flag <= 1'b1;
            else if (al_clr) al_flag <= 1'b0;
            if (set_evt)     irq <= 1'b1;
            else if (al_clr) irq <= 1'b0;
        end
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> (al_flag && irq));
    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (al_clr && !set_evt) |=> (!al_flag && !irq));
    p_mm_drop_r5: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> !mm_bit);
endmodule

// File: rtl/i2c_arb_master.sv
module i2c_arb_master
    import i2c_arb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int QDIV   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              al_clr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              mm_bit,
    output logic              al_flag,
    output logic              irq,
    output logic              bus_busy,
    output logic              xfer_done
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    mst_state_e        st;
    logic [1:0]        q;
    logic [IDX_W-1:0]  bidx;
    logic [DATA_W-1:0] sh;
    logic              lost_q;
    logic              done_q;
    logic              tick;
    bus_view_t         view;
    line_drv_t         drv;

    logic accept, refuse, data_phase, last_bit, lose_now, lost_evt, done_evt;

    i2c_line_watch u_watch (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .view   (view)
    );

    i2c_quarter_tick #(.QDIV(QDIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (st != ST_IDLE),
        .tick (tick)
    );

    assign accept     = start_req && (st == ST_IDLE) && !view.busy;
    assign refuse     = start_req && (st == ST_IDLE) &&  view.busy;
    assign data_phase = (st == ST_BIT) && (bidx < IDX_W'(DATA_W));
    assign last_bit   = (bidx == IDX_W'(DATA_W));
    assign lose_now   = data_phase && q[1] && sh[DATA_W-1] && !lost_q
                        && view.scl && !view.sda;
    assign lost_evt   = tick && (st == ST_BIT) && (q == 2'd3) && last_bit && lost_q;
    assign done_evt   = tick && (st == ST_STOP_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            q      <= '0;
            bidx   <= '0;
            sh     <= '0;
            lost_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= done_evt;
            if (st == ST_IDLE) begin
                lost_q <= 1'b0;
                if (accept) begin
                    st   <= ST_START_A;
                    sh   <= tx_byte;
                    q    <= '0;
                    bidx <= '0;
                end
            end else begin
                if (lose_now) lost_q <= 1'b1;
                if (tick) begin
                    case (st)
                        ST_START_A: st <= ST_START_B;
                        ST_START_B: begin
                            st   <= ST_BIT;
                            q    <= '0;
                            bidx <= '0;
                        end
                        ST_BIT: begin
                            if (q != 2'd3) begin
                                q <= q + 2'd1;
                            end else if (last_bit) begin
                                st <= ST_END;
                            end else begin
                                q    <= '0;
                                bidx <= bidx + IDX_W'(1);
                                sh   <= {sh[DATA_W-2:0], 1'b0};
                            end
                        end
                        ST_END:    st <= lost_q ? ST_IDLE : ST_STOP_B;
                        ST_STOP_B: st <= ST_STOP_C;
                        ST_STOP_C: st <= ST_IDLE;
                        default:   st <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    assign drv = line_drive(st, q, data_phase, sh[DATA_W-1], lost_q);

    assign scl_oe    = drv.scl_low;
    assign sda_oe    = drv.sda_low;
    assign bus_busy  = view.busy;
    assign xfer_done = done_q;

    i2c_arb_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .refuse   (refuse),
        .lost_evt (lost_evt),
        .done_evt (done_evt),
        .al_clr   (al_clr),
        .mm_bit   (mm_bit),
        .al_flag  (al_flag),
        .irq      (irq)
    );

    // SDA may only move while SCL is held low.
    p_hold_high_r2: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_BIT) && q[1] && $past((st == ST_BIT) && q[1])) |-> $stable(sda_oe));
    // Once lost, SDA is never pulled for the rest of the byte.
    p_lost_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (lost_q && $past(lost_q)) |-> !sda_oe);
    // A loss is flagged only at the edge that ends the ninth pulse.
    p_loss_at_ninth_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(al_flag) && !$past(refuse)) |-> ((st == ST_END) && lost_q && scl_oe));
    // A refused request leaves the engine idle with the flag set.
    p_refuse_r8: assert property (@(posedge clk) disable iff (rst)
        refuse |=> (al_flag && !mm_bit && (st == ST_IDLE)));
endmodule

// File: tb/i2c_arb_master_bench.sv
module i2c_arb_master_bench;
    localparam int QD = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       al_clr = 1'b0;
    logic       b_scl_oe = 1'b0;
    logic       b_sda_oe = 1'b0;
    logic       scl_oe, sda_oe, mm_bit, al_flag, irq, bus_busy, xfer_done;
    logic       scl_ln, sda_ln;
    int         errors = 0;
    int         checks = 0;
    bit         finished = 1'b0;

    assign scl_ln = !(scl_oe | b_scl_oe);
    assign sda_ln = !(sda_oe | b_sda_oe);

    always #5 clk = ~clk;

    i2c_arb_master #(.DATA_W(8), .QDIV(QD)) u_i2c_arb_master (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .tx_byte   (tx_byte),
        .al_clr    (al_clr),
        .scl_in    (scl_ln),
        .sda_in    (sda_ln),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .mm_bit    (mm_bit),
        .al_flag   (al_flag),
        .irq       (irq),
        .bus_busy  (bus_busy),
        .xfer_done (xfer_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk) al_clr = 1'b1;
        @(negedge clk) al_clr = 1'b0;
    endtask

    // One byte from the design against a competing master sending b.
    task automatic run_byte(input logic [7:0] d, input logic [7:0] b);
        int   first;
        int   n;
        logic dut_lost;
        logic bl;
        logic exp_drv;
        first = -1;
        for (int k = 0; k < 8; k++)
            if (first < 0 && d[7-k] != b[7-k]) first = k;
        dut_lost = (first >= 0) && d[7-first];

        tx_byte = d;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        chk("R2 start sda pulled", {31'd0, sda_oe}, 1);
        chk("R2 start scl free", {31'd0, scl_oe}, 0);
        b_sda_oe = 1'b1;
        bl = 1'b0;
        for (int k = 0; k < 9; k++) begin
            @(negedge scl_ln); #1;
            if (k == 8) begin
                chk("R5 flag low before ninth fall", {31'd0, al_flag}, 0);
                chk("R2 master bit during byte", {31'd0, mm_bit}, 1);
            end
            b_sda_oe = (k < 8) ? (!bl && !b[7-k]) : 1'b0;
            @(posedge scl_ln); #1;
            exp_drv = (k < 8) && (!dut_lost || k <= first) && !d[7-k];
            chk("R3 sda drive per bit", {31'd0, sda_oe}, {31'd0, exp_drv});
            if (k < 8 && !bl && b[7-k] && !sda_ln) bl = 1'b1;
        end
        @(negedge scl_ln); #1;
        chk("R5 flag at ninth fall", {31'd0, al_flag}, {31'd0, dut_lost});
        chk("R5 irq at ninth fall", {31'd0, irq}, {31'd0, dut_lost});
        chk("R5 master bit at ninth fall", {31'd0, mm_bit}, {31'd0, !dut_lost});
        chk("R4 ninth fall driven by block", {31'd0, scl_oe}, 1);
        chk("R10 sda at ninth fall", {31'd0, sda_oe}, {31'd0, !dut_lost});
        if (dut_lost) begin
            b_scl_oe = 1'b1;
            repeat (4 * QD) @(negedge clk);
            chk("R10 lines released after loss", {30'd0, scl_oe, sda_oe}, 0);
            b_sda_oe = 1'b1;
            repeat (2) @(negedge clk);
            b_scl_oe = 1'b0;
            repeat (2) @(negedge clk);
            b_sda_oe = 1'b0;
            repeat (4) @(negedge clk);
        end else begin
            n = 0;
            while (!xfer_done && n < 50) begin
                @(negedge clk);
                n++;
            end
            chk("R6 done pulse after stop", {31'd0, xfer_done}, 1);
            repeat (4) @(negedge clk);
            chk("R6 no flag on win", {31'd0, al_flag}, 0);
        end
        chk("R7 bus free after stop", {31'd0, bus_busy}, 0);
        chk("R6 master bit cleared", {31'd0, mm_bit}, 0);
        if (dut_lost) begin
            pulse_clr();
            chk("R9 flag cleared", {31'd0, al_flag}, 0);
            chk("R9 irq cleared", {31'd0, irq}, 0);
        end
    endtask

    task automatic busy_refusal();
        int pulls;
        b_sda_oe = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 busy after foreign start", {31'd0, bus_busy}, 1);
        tx_byte = 8'h00;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        chk("R8 flag on refusal", {31'd0, al_flag}, 1);
        chk("R8 irq on refusal", {31'd0, irq}, 1);
        chk("R8 master bit stays 0", {31'd0, mm_bit}, 0);
        pulls = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (scl_oe || sda_oe) pulls++;
        end
        chk("R8 nothing on lines", pulls, 0);
        @(negedge clk) begin start_req = 1'b1; al_clr = 1'b1; end
        @(negedge clk) begin start_req = 1'b0; al_clr = 1'b0; end
        chk("R9 set wins over clear", {31'd0, al_flag}, 1);
        pulse_clr();
        chk("R9 lone clear drops flag", {31'd0, al_flag}, 0);
        chk("R9 lone clear drops irq", {31'd0, irq}, 0);
        b_sda_oe = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 free after foreign stop", {31'd0, bus_busy}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 scl enable", {31'd0, scl_oe}, 0);
        chk("R1 sda enable", {31'd0, sda_oe}, 0);
        chk("R1 master bit", {31'd0, mm_bit}, 0);
        chk("R1 flag", {31'd0, al_flag}, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 busy", {31'd0, bus_busy}, 0);
        busy_refusal();
        for (int d = 0; d < 256; d++) begin
            run_byte(d[7:0], 8'h00);
            run_byte(d[7:0], 8'h96);
            run_byte(d[7:0], d[7:0]);
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule